// File: doc/BRIEF.md
# Loadable Burst Address Counter

This block sits in front of one port of a synchronous memory and settles, on every rising clock edge, which word that port touches during the coming cycle. A port can take a fresh address from its bus, walk forward one word at a time through a burst, stay on the current word, or jump back to word zero. The result is held in the counter register, and that register drives the array address directly. The address accessed in a cycle is therefore always the value the counter holds, and the next step starts from it.

The three controls are active low and are sampled at the clock edge. Clearing beats loading, and loading beats stepping. With no control asserted the counter keeps its value, so repeated reads return the same word. All controls are plain per-cycle levels. The block has no handshake and never stalls, because every cycle yields exactly one address. It has no chip-enable or byte-select inputs, so the counter acts on every edge no matter how the rest of the port is selected. A clear uses up no cycle: the word at address zero is accessed in the cycle the clear takes effect.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `int_addr` becomes 0 after that edge, whatever the other inputs are.
- R2: With `rst_n` high and `zero_n` sampled low, `int_addr` becomes 0 after the edge, whatever `load_n`, `step_n` and `ext_addr` are.
- R3: With `zero_n` high and `load_n` sampled low, `int_addr` takes the sampled `ext_addr`, whatever `step_n` is.
- R4: With `zero_n` and `load_n` high and `step_n` sampled low, `int_addr` becomes its previous value plus one.
- R5: With `zero_n`, `load_n` and `step_n` all sampled high, `int_addr` keeps its value.
- R6: Stepping from the all-ones address (8191 for the 13-bit default) gives address 0.
- R7: The value on `int_addr` is the address accessed in that cycle and the base for the next step. A load or clear followed at once by a step yields the loaded value plus one, or 1, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything happens on the rising edge |
| rst_n | input | 1 | Synchronous system reset, active low |
| ext_addr | input | ADDR_W | Address taken from the port's bus |
| load_n | input | 1 | Active-low strobe that loads `ext_addr` |
| step_n | input | 1 | Active-low enable that advances the counter by one |
| zero_n | input | 1 | Active-low counter clear to address 0 |
| int_addr | output | ADDR_W | Address accessed by the port in the current cycle |

## Verification
The bench builds two copies side by side and drives them with the same controls. One uses the default 13-bit width. The other uses a 4-bit width and receives the low bits of the bus address. In the 13-bit copy, wrap is reached by loading 8191 and stepping once. The 4-bit copy wraps every sixteen steps, so a plain run of steps crosses the all-ones boundary several times and checks that the count continues correctly after each wrap, which the wide copy could not reach within the run's length.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } addr_op_e;

endpackage

// File: rtl/burst_addr_decode.sv
module burst_addr_decode
  import burst_addr_pkg::*;
(
  input  logic     zero_n,
  input  logic     load_n,
  input  logic     step_n,
  output addr_op_e op
);

  // Priority: clear, then load, then step, otherwise hold.
  always_comb begin
    if (!zero_n)      op = OP_CLEAR;
    else if (!load_n) op = OP_LOAD;
    else if (!step_n) op = OP_STEP;
    else              op = OP_HOLD;
  end

endmodule

// File: rtl/burst_addr_next.sv
module burst_addr_next
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  addr_op_e          op,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] ext,
  output logic [ADDR_W-1:0] nxt
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] inc;

  // Modulo increment: the carry out of the top bit is dropped.
  assign inc = cur + ONE;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = ext;
      OP_STEP:  nxt = inc;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // R1: synchronous reset forces the counter to zero
  p_sync_reset_r1: assert property (@(posedge clk) !rst_n |=> (q == '0));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              load_n,
  input  logic              step_n,
  input  logic              zero_n,
  output logic [ADDR_W-1:0] int_addr
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  addr_op_e          op;
  logic [ADDR_W-1:0] nxt;

  burst_addr_decode u_decode (
    .zero_n (zero_n),
    .load_n (load_n),
    .step_n (step_n),
    .op     (op)
  );

  burst_addr_next #(.ADDR_W(ADDR_W)) u_next (
    .op  (op),
    .cur (int_addr),
    .ext (ext_addr),
    .nxt (nxt)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (nxt),
    .q     (int_addr)
  );

  // R2: clear wins over every other control
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_n |=> (int_addr == '0));

  // R3: load takes the bus address, whatever the step enable
  p_load_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && !load_n) |=> (int_addr == $past(ext_addr)));

  // R4: a step adds one to the current address
  p_step_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && load_n && !step_n) |=> (int_addr == ADDR_W'($past(int_addr) + 1'b1)));

  // R5: no control asserted keeps the address
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && load_n && step_n) |=> $stable(int_addr));

  // R6: stepping off the top address wraps to zero
  p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_n && load_n && !step_n && int_addr == TOP_ADDR) |=> (int_addr == '0));

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  localparam int WW = 13;
  localparam int NW = 4;

  typedef struct {
    logic [WW-1:0] exp_w;
    logic [NW-1:0] exp_n;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [WW-1:0] ext_addr = '0;
  logic          load_n = 1'b1;
  logic          step_n = 1'b1;
  logic          zero_n = 1'b1;
  logic [WW-1:0] addr_w;
  logic [NW-1:0] addr_n;

  item_t         sb[$];
  logic [WW-1:0] m_w = '0;
  logic [NW-1:0] m_n = '0;
  int            vectors = 0;
  int            miscompares = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(WW)) i_burst_addr_gen (
    .clk (clk), .rst_n (rst_n), .ext_addr (ext_addr),
    .load_n (load_n), .step_n (step_n), .zero_n (zero_n),
    .int_addr (addr_w)
  );

  burst_addr_gen #(.ADDR_W(NW)) i_burst_addr_gen_narrow (
    .clk (clk), .rst_n (rst_n), .ext_addr (ext_addr[NW-1:0]),
    .load_n (load_n), .step_n (step_n), .zero_n (zero_n),
    .int_addr (addr_n)
  );

  // Driver: applies one cycle of controls and queues the expected addresses.
  task automatic drive(input logic rst, input logic zr, input logic ld,
                       input logic st, input logic [WW-1:0] ext, input string tag);
    item_t it;
    @(negedge clk);
    rst_n = rst; zero_n = zr; load_n = ld; step_n = st; ext_addr = ext;
    if (!rst || !zr) begin
      m_w = '0; m_n = '0;
    end else if (!ld) begin
      m_w = ext; m_n = ext[NW-1:0];
    end else if (!st) begin
      m_w = (m_w == {WW{1'b1}}) ? '0 : m_w + 1'b1;
      m_n = (m_n == {NW{1'b1}}) ? '0 : m_n + 1'b1;
    end
    it.exp_w = m_w; it.exp_n = m_n; it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compares after each rising edge, midway to the falling edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        vectors++;
        if (addr_w !== it.exp_w || addr_n !== it.exp_n) begin
          miscompares++;
          $display("FAIL %s: wide got %0d exp %0d, narrow got %0d exp %0d",
                   it.tag, addr_w, it.exp_w, addr_n, it.exp_n);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    drive(0, 1, 1, 1, 13'd0,    "R1 reset");
    drive(0, 1, 0, 0, 13'd77,   "R1 reset beats load");
    drive(1, 1, 0, 1, 13'h1234, "R3 load");
    drive(1, 1, 1, 0, 13'd0,    "R4 step");
    drive(1, 1, 1, 0, 13'd5,    "R4 step ignores bus");
    drive(1, 1, 1, 0, 13'd0,    "R4 step");
    drive(1, 1, 1, 1, 13'd9,    "R5 hold");
    drive(1, 1, 1, 1, 13'd0,    "R5 hold");
    drive(1, 1, 0, 0, 13'h0AAA, "R3 load beats step");
    drive(1, 0, 0, 0, 13'h0555, "R2 clear beats load and step");
    drive(1, 1, 1, 0, 13'd0,    "R7 step right after clear");
    drive(1, 1, 1, 1, 13'd0,    "R5 hold after clear");
    drive(1, 1, 0, 1, 13'd8191, "R3 load top");
    drive(1, 1, 1, 0, 13'd0,    "R6 wrap");
    drive(1, 1, 0, 1, 13'd300,  "R3 load");
    drive(1, 1, 1, 0, 13'd0,    "R7 step right after load");
    drive(1, 0, 1, 1, 13'd0,    "R2 clear");
    for (int i = 0; i < 40; i++) drive(1, 1, 1, 0, 13'd0, "R6 narrow wrap run");
    drive(0, 1, 0, 1, 13'd99,   "R1 mid-run reset");
    drive(1, 1, 1, 0, 13'd0,    "R4 step after reset");
    drive(1, 1, 1, 1, 13'd0,    "R5 hold");
    @(negedge clk);
    rst_n = 1'b1; zero_n = 1'b1; load_n = 1'b1; step_n = 1'b1;
    while (sb.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule